// File: doc/BRIEF.md
# Single-Register Fetch-Execute Core

This block is a very small 8-bit processor. It has one working register (the accumulator), a program counter, and a 256-byte memory inside the block. Code and data share that memory. The core steps through a fixed loop: read a byte at the program counter, advance the counter and classify the byte, then carry out the operation. There are only three legal operations: add one to the accumulator, subtract one from it, and write the accumulator to the address given by its bitwise complement. Any other byte stops the core.

A test environment uses it as follows. It holds the run input low and applies reset, which loads the start address and the starting accumulator value from input ports. It then fills the memory through the preload port and raises run. A debug read port returns any memory byte at any time. The program counter, accumulator, halt flag and a running flag are visible as outputs.

Top module: `tiny_acc_core`

## Requirements
- R1: The memory holds 256 bytes and is addressed by 8 bits. The debug port returns the byte at `dbg_addr` combinationally, and the same array serves instruction fetches and data stores.
- R2: While `rst_n` is low at a clock edge, the program counter takes `boot_pc`, the accumulator takes `boot_acc`, and the halt flag clears. The memory contents are not changed by reset.
- R3: A preload write (`ld_we` high) is stored only when `run` is low. With `run` high it is ignored and the byte at `ld_addr` keeps its value.
- R4: While `run` is low, the program counter, accumulator and halt flag do not change, and the sequencer holds its current step.
- R5: Each instruction takes three clock cycles: fetch at the program counter; then program counter plus one together with decode; then execute. The program counter wraps modulo 256 and only ever advances by one.
- R6: Byte 0xF0 adds one to the accumulator, modulo 256 (0xFF becomes 0x00).
- R7: Byte 0xF2 subtracts one from the accumulator, modulo 256 (0x00 becomes 0xFF).
- R8: Byte 0x5F writes the accumulator to the memory byte whose address is the bitwise NOT of the accumulator. The accumulator is unchanged.
- R9: Any other byte sets `halted_o` at the end of its decode cycle, two cycles after its fetch began. The program counter then points one past that byte and the accumulator is unchanged. After that, no state changes until reset.
- R10: A store whose target is the byte the program counter fetches next takes effect before that fetch. The new byte is the one that executes.
- R11: `running_o` is high exactly when `run` is high and the core is not halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | High lets the sequencer advance; low freezes it and opens the preload port |
| boot_pc | input | 8 | Program counter value loaded in reset |
| boot_acc | input | 8 | Accumulator value loaded in reset |
| ld_we | input | 1 | Preload write strobe |
| ld_addr | input | 8 | Preload write address |
| ld_data | input | 8 | Preload write data |
| dbg_addr | input | 8 | Debug read address |
| dbg_data | output | 8 | Memory byte at `dbg_addr` |
| pc_o | output | 8 | Program counter |
| acc_o | output | 8 | Accumulator |
| halted_o | output | 1 | Core stopped on an illegal byte |
| running_o | output | 1 | Core is advancing |

## Verification
The assertions check on every cycle that the halt flag is sticky and that it freezes the program counter and accumulator. They also check that a low `run` freezes the same state, that the accumulator only moves by plus or minus one, that the program counter only moves by plus one, and that the core writes memory only while running. Only the bench's scenarios can show that each opcode has the right effect at the right cycle, that the complemented store address and the wrap corners come out right, and that a store into the next instruction byte changes what executes. The same holds for a preload attempted while running being dropped: the bench shows it by reading the memory back through the debug port and comparing every byte with its own model.

// File: rtl/tac_pkg.sv
package tac_pkg;

    localparam int unsigned TAC_W = 8;

    localparam logic [TAC_W-1:0] OPC_INC = 8'hF0;
    localparam logic [TAC_W-1:0] OPC_DEC = 8'hF2;
    localparam logic [TAC_W-1:0] OPC_STO = 8'h5F;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_EXEC   = 2'd2,
        ST_HALT   = 2'd3
    } tac_state_e;

    typedef enum logic [1:0] {
        OPK_INC = 2'd0,
        OPK_DEC = 2'd1,
        OPK_STO = 2'd2,
        OPK_BAD = 2'd3
    } tac_op_e;

    typedef struct packed {
        tac_state_e       state;
        logic [TAC_W-1:0] pc;
        logic [TAC_W-1:0] ir;
        logic [TAC_W-1:0] acc;
    } tac_regs_t;

endpackage

// File: rtl/tac_dec.sv
module tac_dec
    import tac_pkg::*;
(
    input  logic [TAC_W-1:0] code_i,
    output tac_op_e          kind_o
);
    always_comb begin
        unique case (code_i)
            OPC_INC: kind_o = OPK_INC;
            OPC_DEC: kind_o = OPK_DEC;
            OPC_STO: kind_o = OPK_STO;
            default: kind_o = OPK_BAD;
        endcase
    end
endmodule

// File: rtl/tac_alu.sv
module tac_alu
    import tac_pkg::*;
#(
    parameter int unsigned W = TAC_W
) (
    input  logic [W-1:0] acc_i,
    input  tac_op_e      kind_i,
    output logic [W-1:0] acc_o,
    output logic [W-1:0] st_addr_o
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        unique case (kind_i)
            OPK_INC: acc_o = acc_i + ONE;
            OPK_DEC: acc_o = acc_i - ONE;
            default: acc_o = acc_i;
        endcase
        st_addr_o = ~acc_i;
    end
endmodule

// File: rtl/tac_mem.sv
module tac_mem #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         wr_en,
    input  logic [W-1:0] wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    input  logic [W-1:0] rd_addr,
    output logic [W-1:0] rd_data,
    input  logic [W-1:0] dbg_addr,
    output logic [W-1:0] dbg_data
);
    localparam int unsigned DEPTH = 1 << W;

    logic [W-1:0] cells_q [DEPTH];
    logic [W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells_q[wr_addr] <= wr_data;
        end
    end

    // synchronous fetch port: byte is available after the edge
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_q <= cells_q[rd_addr];
        end
    end

    assign rd_data  = rd_q;
    assign dbg_data = cells_q[dbg_addr];
endmodule

// File: rtl/tac_seq.sv
module tac_seq
    import tac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TAC_W-1:0] boot_pc,
    input  logic [TAC_W-1:0] boot_acc,
    input  logic [TAC_W-1:0] rd_data,
    output logic             rd_en,
    output logic [TAC_W-1:0] rd_addr,
    output logic             wr_en,
    output logic [TAC_W-1:0] wr_addr,
    output logic [TAC_W-1:0] wr_data,
    output logic [TAC_W-1:0] pc_o,
    output logic [TAC_W-1:0] acc_o,
    output logic             halted_o
);
    localparam logic [TAC_W-1:0] PC_STEP = TAC_W'(1);

    tac_regs_t        regs_q, regs_d;
    logic [TAC_W-1:0] dec_in;
    tac_op_e          op_kind;
    logic [TAC_W-1:0] alu_acc;
    logic [TAC_W-1:0] alu_addr;

    // classify the fresh byte during decode, the held byte during execute
    assign dec_in = (regs_q.state == ST_DECODE) ? rd_data : regs_q.ir;

    tac_dec u_dec (
        .code_i (dec_in),
        .kind_o (op_kind)
    );

    tac_alu #(.W(TAC_W)) u_alu (
        .acc_i     (regs_q.acc),
        .kind_i    (op_kind),
        .acc_o     (alu_acc),
        .st_addr_o (alu_addr)
    );

    always_comb begin
        regs_d  = regs_q;
        rd_en   = 1'b0;
        rd_addr = regs_q.pc;
        wr_en   = 1'b0;
        wr_addr = alu_addr;
        wr_data = regs_q.acc;
        if (run) begin
            unique case (regs_q.state)
                ST_FETCH: begin
                    rd_en        = 1'b1;
                    regs_d.state = ST_DECODE;
                end
                ST_DECODE: begin
                    regs_d.ir    = rd_data;
                    regs_d.pc    = regs_q.pc + PC_STEP;
                    regs_d.state = (op_kind == OPK_BAD) ? ST_HALT : ST_EXEC;
                end
                ST_EXEC: begin
                    unique case (op_kind)
                        OPK_INC, OPK_DEC: regs_d.acc = alu_acc;
                        OPK_STO:          wr_en      = 1'b1;
                        default:          regs_d.acc = regs_q.acc;
                    endcase
                    regs_d.state = ST_FETCH;
                end
                default: regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.state <= ST_FETCH;
            regs_q.pc    <= boot_pc;
            regs_q.ir    <= '0;
            regs_q.acc   <= boot_acc;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign pc_o     = regs_q.pc;
    assign acc_o    = regs_q.acc;
    assign halted_o = (regs_q.state == ST_HALT);
endmodule

// File: rtl/tiny_acc_core.sv
module tiny_acc_core
    import tac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TAC_W-1:0] boot_pc,
    input  logic [TAC_W-1:0] boot_acc,
    input  logic             ld_we,
    input  logic [TAC_W-1:0] ld_addr,
    input  logic [TAC_W-1:0] ld_data,
    input  logic [TAC_W-1:0] dbg_addr,
    output logic [TAC_W-1:0] dbg_data,
    output logic [TAC_W-1:0] pc_o,
    output logic [TAC_W-1:0] acc_o,
    output logic             halted_o,
    output logic             running_o
);
    logic             core_rd_en;
    logic [TAC_W-1:0] core_rd_addr;
    logic             core_we;
    logic [TAC_W-1:0] core_wr_addr;
    logic [TAC_W-1:0] core_wr_data;
    logic [TAC_W-1:0] fetch_data;
    logic             pre_we;
    logic             mem_we;
    logic [TAC_W-1:0] mem_wa;
    logic [TAC_W-1:0] mem_wd;

    // the preload path owns the write port only while the core is frozen
    assign pre_we = ld_we && !run;
    assign mem_we = pre_we || core_we;
    assign mem_wa = pre_we ? ld_addr : core_wr_addr;
    assign mem_wd = pre_we ? ld_data : core_wr_data;

    tac_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .boot_pc  (boot_pc),
        .boot_acc (boot_acc),
        .rd_data  (fetch_data),
        .rd_en    (core_rd_en),
        .rd_addr  (core_rd_addr),
        .wr_en    (core_we),
        .wr_addr  (core_wr_addr),
        .wr_data  (core_wr_data),
        .pc_o     (pc_o),
        .acc_o    (acc_o),
        .halted_o (halted_o)
    );

    tac_mem #(.W(TAC_W)) u_mem (
        .clk      (clk),
        .wr_en    (mem_we),
        .wr_addr  (mem_wa),
        .wr_data  (mem_wd),
        .rd_en    (core_rd_en),
        .rd_addr  (core_rd_addr),
        .rd_data  (fetch_data),
        .dbg_addr (dbg_addr),
        .dbg_data (dbg_data)
    );

    assign running_o = run && !halted_o;
endmodule

// File: rtl/tac_chk.sv
module tac_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       run,
    input logic [7:0] pc_o,
    input logic [7:0] acc_o,
    input logic       halted_o,
    input logic       store_we
);
    logic armed_q;

    always_ff @(posedge clk) begin
        armed_q <= rst_n;
    end

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> halted_o);

    // R9
    halt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> ($stable(pc_o) && $stable(acc_o)));

    // R4
    idle_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(pc_o) && $stable(acc_o) && $stable(halted_o)));

    // R6 R7
    acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$stable(acc_o)) |->
            ((acc_o == $past(acc_o) + 8'd1) || (acc_o == $past(acc_o) - 8'd1)));

    // R5
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$stable(pc_o)) |-> (pc_o == $past(pc_o) + 8'd1));

    // R8
    store_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_we |-> (run && !halted_o));
endmodule

bind tiny_acc_core tac_chk u_tac_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .pc_o     (pc_o),
    .acc_o    (acc_o),
    .halted_o (halted_o),
    .store_we (core_we)
);

// File: tb/test_tiny_acc_core.sv
`timescale 1ns/1ps
module test_tiny_acc_core;

    typedef enum int {K_PC, K_ACC, K_HALT, K_RUN, K_MEM} kind_e;
    typedef struct {
        kind_e      kind;
        logic [7:0] addr;
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [7:0] boot_pc = '0;
    logic [7:0] boot_acc = '0;
    logic       ld_we = 1'b0;
    logic [7:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [7:0] dbg_addr = '0;
    logic [7:0] dbg_data;
    logic [7:0] pc_o;
    logic [7:0] acc_o;
    logic       halted_o;
    logic       running_o;

    int n_cmp = 0;
    int n_bad = 0;
    item_t sb_q[$];

    logic [7:0] ref_mem [256];
    logic [7:0] ref_pc;
    logic [7:0] ref_acc;
    logic       ref_halt;

    always #10 clk = ~clk;

    tiny_acc_core i_tiny_acc_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .boot_pc   (boot_pc),
        .boot_acc  (boot_acc),
        .ld_we     (ld_we),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .dbg_addr  (dbg_addr),
        .dbg_data  (dbg_data),
        .pc_o      (pc_o),
        .acc_o     (acc_o),
        .halted_o  (halted_o),
        .running_o (running_o)
    );

    task automatic push(input kind_e k, input logic [7:0] a, input logic [7:0] e, input string t);
        item_t it;
        it.kind = k; it.addr = a; it.exp = e; it.tag = t;
        sb_q.push_back(it);
    endtask

    // monitor: pops expected items and compares against the ports
    task automatic drain();
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            act = '0;
            case (it.kind)
                K_PC:   act = pc_o;
                K_ACC:  act = acc_o;
                K_HALT: act = {7'd0, halted_o};
                K_RUN:  act = {7'd0, running_o};
                K_MEM: begin
                    dbg_addr = it.addr;
                    #1;
                    act = dbg_data;
                end
                default: act = 'x;
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: item %0d addr %02h actual %02h expected %02h",
                         it.tag, it.kind, it.addr, act, it.exp);
            end
        end
    endtask

    task automatic boot(input logic [7:0] p, input logic [7:0] a);
        @(negedge clk);
        run = 1'b0; rst_n = 1'b0; boot_pc = p; boot_acc = a;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        ref_pc = p; ref_acc = a; ref_halt = 1'b0;
        // R2: reset values; R11: not running while run is low
        push(K_PC, 8'h00, p, "R2");
        push(K_ACC, 8'h00, a, "R2");
        push(K_HALT, 8'h00, 8'h00, "R2");
        push(K_RUN, 8'h00, 8'h00, "R11");
        drain();
    endtask

    task automatic preload();
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            ld_we = 1'b1; ld_addr = 8'(i); ld_data = ref_mem[i];
        end
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic run_prog(input int freeze_at);
        int steps;
        steps = 0;
        run = 1'b1;
        while (!ref_halt && steps < 64) begin
            logic [7:0] op;
            string t;
            op = ref_mem[ref_pc];
            ref_pc = ref_pc + 8'd1;
            case (op)
                8'hF0: begin ref_acc = ref_acc + 8'd1; t = "R6"; end
                8'hF2: begin ref_acc = ref_acc - 8'd1; t = "R7"; end
                8'h5F: begin ref_mem[~ref_acc] = ref_acc; t = "R8"; end
                default: begin ref_halt = 1'b1; t = "R9"; end
            endcase
            repeat (ref_halt ? 2 : 3) @(posedge clk);
            @(negedge clk);
            push(K_PC, 8'h00, ref_pc, "R5");
            push(K_ACC, 8'h00, ref_acc, t);
            push(K_HALT, 8'h00, {7'd0, ref_halt}, ref_halt ? "R9" : "R5");
            push(K_RUN, 8'h00, {7'd0, !ref_halt}, "R11");
            drain();
            if (steps == freeze_at) begin
                run = 1'b0;
                repeat (6) @(negedge clk);
                push(K_PC, 8'h00, ref_pc, "R4");
                push(K_ACC, 8'h00, ref_acc, "R4");
                push(K_RUN, 8'h00, 8'h00, "R11");
                drain();
                run = 1'b1;
            end
            steps++;
        end
        // R9: nothing moves after the halt
        repeat (5) @(negedge clk);
        push(K_PC, 8'h00, ref_pc, "R9");
        push(K_ACC, 8'h00, ref_acc, "R9");
        push(K_HALT, 8'h00, 8'h01, "R9");
        drain();
    endtask

    task automatic check_mem(input string t);
        for (int i = 0; i < 256; i++) begin
            push(K_MEM, 8'(i), ref_mem[i], t);
        end
        drain();
    endtask

    task automatic clear_image();
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual still running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // program A: increment, complemented store, illegal byte
        clear_image();
        ref_mem[8'h0C] = 8'hF0;
        ref_mem[8'h0D] = 8'h5F;
        boot(8'h0C, 8'hF2);
        preload();
        // R1: debug read sees preloaded bytes
        push(K_MEM, 8'h0D, 8'h5F, "R1");
        push(K_MEM, 8'h80, 8'h00, "R1");
        drain();
        // R3: a preload held active while running must be dropped
        ld_we = 1'b1; ld_addr = 8'h80; ld_data = 8'hAA;
        run_prog(-1);
        ld_we = 1'b0;
        push(K_MEM, 8'h80, 8'h00, "R3");
        push(K_MEM, 8'h0C, 8'hF3, "R8");
        drain();
        check_mem("R8");

        // program B: wrap corners, freeze, store at 0x00 -> address 0xFF
        clear_image();
        ref_mem[8'h20] = 8'hF0;
        ref_mem[8'h21] = 8'hF2;
        ref_mem[8'h22] = 8'hF2;
        ref_mem[8'h23] = 8'hF0;
        ref_mem[8'h24] = 8'hF0;
        ref_mem[8'h25] = 8'hF2;
        ref_mem[8'h26] = 8'hF0;
        ref_mem[8'h27] = 8'h5F;
        ref_mem[8'h28] = 8'hFF;
        ref_mem[8'hFF] = 8'h77;
        boot(8'h20, 8'hFF);
        preload();
        run_prog(0);
        push(K_ACC, 8'h00, 8'h00, "R6");
        push(K_MEM, 8'hFF, 8'h00, "R8");
        push(K_PC, 8'h00, 8'h29, "R9");
        drain();
        check_mem("R8");

        // program C: store rewrites the very next instruction byte
        clear_image();
        ref_mem[8'h0E] = 8'h5F;
        boot(8'h0E, 8'hF0);
        preload();
        run_prog(-1);
        push(K_ACC, 8'h00, 8'hF1, "R10");
        push(K_MEM, 8'h0F, 8'hF0, "R10");
        push(K_PC, 8'h00, 8'h11, "R10");
        drain();
        check_mem("R10");

        // program D: wrap at the top of memory, decrement below zero
        clear_image();
        ref_mem[8'hFF] = 8'hF2;
        ref_mem[8'h00] = 8'hF2;
        ref_mem[8'h01] = 8'h12;
        boot(8'hFF, 8'h00);
        preload();
        run_prog(-1);
        push(K_ACC, 8'h00, 8'hFE, "R7");
        push(K_PC, 8'h00, 8'h02, "R5");
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule